// File: doc/BRIEF.md
# Peer Victim-Region Castout Router

This block sits beside a shared last-level cache that is divided into eight regions. Each region is the first-choice victim store for its own private L2, and it also takes lines evicted by the other seven. When a region evicts a line, the router settles where that line ends up. The line can be written back to memory, folded into copies of it that other regions already hold, or offered to one chosen peer region. That peer then answers with accept or reject.

Requests arrive one at a time over a valid/ready handshake. Each request carries the line address, the evicting region and a dirty flag. Alongside the request, the cache presents a per-region mask that marks which regions already hold a clone of the line. The router keeps a small saturating occupancy counter for every region. A counter rises each time its region accepts a line and falls by one at a programmable interval. The router uses these counters to pick a target and to decide when every peer is too busy to take more lines. Each request ends with a one-cycle result pulse that carries an outcome code and, where one applies, the region involved.

Top module: `castout_router`

## Requirements
- R1: Only one eviction is in flight at a time. `evReady` is high only while the router is idle and drops in the cycle after a request is accepted. It rises again in the cycle the result is reported.
- R2: A peer is full when its occupancy count is strictly greater than `thresh`. If every region other than the source is full, the line goes to memory with outcome code 0. This holds even when clones exist. The source's own count plays no part in the decision.
- R3: If the memory decision is not taken and `cloneMask` has any bit set other than the source's own bit, `mergeValid` pulses for one cycle. `mergeMask` then equals `cloneMask` with the source bit cleared. No peer is offered the line, and the result carries outcome code 1.
- R4: If there are no clones, exactly one peer is offered the line. That peer is the region with the lowest occupancy count, and it is never the source region.
- R5: When several peers tie for the lowest count, the first one found is chosen. The search starts at the rotating pointer and moves upward in region order, wrapping at the top. The pointer resets to 0 and moves up by one, wrapping, after each accepted placement and at no other time.
- R6: `offerValid`, `offerTarget` and `lineAddr` stay stable until `offerAck`. On acceptance the result carries outcome code 2 with `resRegion` set to the target. That region's count then goes up by one.
- R7: A rejected line gets outcome code 3 with `resRegion` set to the target that refused it. A dirty rejected line is written to memory. A clean rejected line is dropped, and `memValid` is never raised for it.
- R8: A memory write holds `memValid` and `lineAddr` until `memReady` is seen.
- R9: All occupancy counts fall by one every `decayPeriod` cycles and stop at 0. They never exceed their maximum. A `decayPeriod` of 0 turns decay off.
- R10: `resValid` is a single-cycle pulse. `resRegion` is 0 for outcomes 0 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| thresh | input | UTIL_W | Occupancy level above which a peer counts as full |
| decayPeriod | input | PERIOD_W | Cycles between count decrements; 0 disables decay |
| evValid | input | 1 | Eviction request valid |
| evReady | output | 1 | Router idle, ready to accept a request |
| evAddr | input | ADDR_W | Address of the evicted line |
| evSrc | input | IDX_W | Evicting region |
| evDirty | input | 1 | Line is modified |
| cloneMask | input | N | Regions holding a clone of the held line |
| lineAddr | output | ADDR_W | Address of the line being handled |
| mergeValid | output | 1 | Merge-into-clones strobe |
| mergeMask | output | N | Clone holders to merge into |
| offerValid | output | 1 | Line offered to a peer |
| offerTarget | output | IDX_W | Region receiving the offer |
| offerDirty | output | 1 | Dirty flag of the offered line |
| offerAck | input | 1 | Peer answer valid |
| offerAccept | input | 1 | Peer accepted (1) or rejected (0) |
| memValid | output | 1 | Memory write request |
| memReady | input | 1 | Memory write taken |
| resValid | output | 1 | Outcome pulse |
| resCode | output | 2 | 0 memory, 1 merged, 2 placed, 3 rejected to memory |
| resRegion | output | IDX_W | Target region for codes 2 and 3 |

## Verification
Call the edge that accepts a request E0. The decision cycle follows E0, so `mergeValid` is due there. `offerValid` and a memory-path `memValid` appear one edge later. Every result is registered, so `resValid` shows up one cycle after whatever completes the request: the merge cycle, the accepting `offerAck`, the `memReady` edge, or the single idle cycle that a clean line spends on the memory path. The bench drives its inputs and samples the outputs on falling edges and counts the edges to each of these points. It also holds acknowledgements back for extra cycles to confirm that requests stay stable while they wait.

// File: rtl/castout_pkg.sv
package castout_pkg;
  typedef enum logic [1:0] {
    OUT_MEM    = 2'd0,
    OUT_MERGE  = 2'd1,
    OUT_PLACE  = 2'd2,
    OUT_REJECT = 2'd3
  } outcome_e;

  typedef struct packed {
    logic     latchReq;
    logic     latchTarget;
    logic     grantPeer;
    logic     finish;
    outcome_e code;
  } ctrl_strobe_t;
endpackage

// File: rtl/castout_util.sv
module castout_util #(
  parameter int N = 8,
  parameter int UTIL_W = 3,
  parameter int PERIOD_W = 16,
  localparam int IDX_W = $clog2(N)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [PERIOD_W-1:0] decayPeriod,
  input  logic                incEn,
  input  logic [IDX_W-1:0]    incIdx,
  output logic [N*UTIL_W-1:0] utilFlat
);
  localparam logic [UTIL_W-1:0] UMAX = '1;

  logic [PERIOD_W-1:0] tickCnt;
  logic decayTick;

  assign decayTick = (decayPeriod != '0) && (tickCnt >= decayPeriod - 1'b1);

  always_ff @(posedge clk) begin
    if (!rstN || decayPeriod == '0 || decayTick) tickCnt <= '0;
    else tickCnt <= tickCnt + 1'b1;
  end

  for (genvar g = 0; g < N; g++) begin : gRegion
    logic [UTIL_W-1:0] cnt;
    logic hit;
    assign hit = incEn && (incIdx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (!rstN) cnt <= '0;
      else if (hit && !decayTick && cnt != UMAX) cnt <= cnt + 1'b1;
      else if (!hit && decayTick && cnt != '0) cnt <= cnt - 1'b1;
    end
    assign utilFlat[g*UTIL_W +: UTIL_W] = cnt;
  end
endmodule

// File: rtl/castout_pick.sv
module castout_pick #(
  parameter int N = 8,
  parameter int UTIL_W = 3,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N*UTIL_W-1:0] utilFlat,
  input  logic [IDX_W-1:0]    src,
  input  logic [IDX_W-1:0]    rrPtr,
  input  logic [UTIL_W-1:0]   thresh,
  output logic                allFull,
  output logic [IDX_W-1:0]    target
);
  always_comb begin
    logic [UTIL_W:0] best;
    allFull = 1'b1;
    target  = rrPtr;
    best    = '1;
    for (int k = 0; k < N; k++) begin
      int idx;
      idx = (int'(rrPtr) + k) % N;
      if (IDX_W'(idx) != src) begin
        if (utilFlat[idx*UTIL_W +: UTIL_W] <= thresh) allFull = 1'b0;
        if ({1'b0, utilFlat[idx*UTIL_W +: UTIL_W]} < best) begin
          best   = {1'b0, utilFlat[idx*UTIL_W +: UTIL_W]};
          target = IDX_W'(idx);
        end
      end
    end
  end
endmodule

// File: rtl/castout_dp.sv
module castout_dp
  import castout_pkg::*;
#(
  parameter int N = 8,
  parameter int UTIL_W = 3,
  parameter int ADDR_W = 16,
  parameter int PERIOD_W = 16,
  localparam int IDX_W = $clog2(N)
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrl_strobe_t        strobe,
  input  logic [UTIL_W-1:0]   thresh,
  input  logic [PERIOD_W-1:0] decayPeriod,
  input  logic [ADDR_W-1:0]   evAddr,
  input  logic [IDX_W-1:0]    evSrc,
  input  logic                evDirty,
  input  logic [N-1:0]        cloneMask,
  output logic [ADDR_W-1:0]   lineAddr,
  output logic [IDX_W-1:0]    reqSrc,
  output logic                reqDirty,
  output logic                cloneHit,
  output logic [N-1:0]        mergeMask,
  output logic                allFull,
  output logic [IDX_W-1:0]    offerTarget,
  output logic                resValid,
  output logic [1:0]          resCode,
  output logic [IDX_W-1:0]    resRegion
);
  logic [IDX_W-1:0] rrPtr, pickTarget, tgtReg;
  logic [N*UTIL_W-1:0] utilFlat;
  logic [N-1:0] srcMask;

  assign srcMask     = N'(1) << reqSrc;
  assign mergeMask   = cloneMask & ~srcMask;
  assign cloneHit    = |mergeMask;
  assign offerTarget = tgtReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineAddr <= '0; reqSrc <= '0; reqDirty <= 1'b0;
      tgtReg <= '0; rrPtr <= '0;
      resValid <= 1'b0; resCode <= '0; resRegion <= '0;
    end else begin
      if (strobe.latchReq) begin
        lineAddr <= evAddr; reqSrc <= evSrc; reqDirty <= evDirty;
      end
      if (strobe.latchTarget) tgtReg <= pickTarget;
      if (strobe.grantPeer)
        rrPtr <= (rrPtr == IDX_W'(N-1)) ? '0 : rrPtr + 1'b1;
      resValid <= strobe.finish;
      if (strobe.finish) begin
        resCode   <= strobe.code;
        resRegion <= (strobe.code == OUT_PLACE || strobe.code == OUT_REJECT) ? tgtReg : '0;
      end
    end
  end

  castout_util #(.N(N), .UTIL_W(UTIL_W), .PERIOD_W(PERIOD_W)) utilI (
    .clk(clk), .rstN(rstN), .decayPeriod(decayPeriod),
    .incEn(strobe.grantPeer), .incIdx(tgtReg), .utilFlat(utilFlat)
  );

  castout_pick #(.N(N), .UTIL_W(UTIL_W)) pickI (
    .utilFlat(utilFlat), .src(reqSrc), .rrPtr(rrPtr), .thresh(thresh),
    .allFull(allFull), .target(pickTarget)
  );
endmodule

// File: rtl/castout_ctrl.sv
module castout_ctrl
  import castout_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         evValid,
  input  logic         allFull,
  input  logic         cloneHit,
  input  logic         reqDirty,
  input  logic         offerAck,
  input  logic         offerAccept,
  input  logic         memReady,
  output logic         evReady,
  output logic         offerValid,
  output logic         memValid,
  output logic         mergeValid,
  output ctrl_strobe_t strobe
);
  typedef enum logic [1:0] {S_IDLE, S_DECIDE, S_OFFER, S_MEMW} state_e;
  state_e state, stateNext;
  outcome_e pendCode, pendNext;

  always_comb begin
    stateNext  = state;
    pendNext   = pendCode;
    strobe     = '0;
    evReady    = 1'b0;
    offerValid = 1'b0;
    memValid   = 1'b0;
    mergeValid = 1'b0;
    unique case (state)
      S_IDLE: begin
        evReady = 1'b1;
        if (evValid) begin
          strobe.latchReq = 1'b1;
          stateNext = S_DECIDE;
        end
      end
      S_DECIDE: begin
        if (allFull) begin
          pendNext  = OUT_MEM;
          stateNext = S_MEMW;
        end else if (cloneHit) begin
          mergeValid    = 1'b1;
          strobe.finish = 1'b1;
          strobe.code   = OUT_MERGE;
          stateNext     = S_IDLE;
        end else begin
          strobe.latchTarget = 1'b1;
          stateNext = S_OFFER;
        end
      end
      S_OFFER: begin
        offerValid = 1'b1;
        if (offerAck) begin
          if (offerAccept) begin
            strobe.grantPeer = 1'b1;
            strobe.finish    = 1'b1;
            strobe.code      = OUT_PLACE;
            stateNext        = S_IDLE;
          end else begin
            pendNext  = OUT_REJECT;
            stateNext = S_MEMW;
          end
        end
      end
      S_MEMW: begin
        memValid = reqDirty;
        if (!reqDirty || memReady) begin
          strobe.finish = 1'b1;
          strobe.code   = pendCode;
          stateNext     = S_IDLE;
        end
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      pendCode <= OUT_MEM;
    end else begin
      state    <= stateNext;
      pendCode <= pendNext;
    end
  end
endmodule

// File: rtl/castout_router.sv
module castout_router
  import castout_pkg::*;
#(
  parameter int N = 8,
  parameter int UTIL_W = 3,
  parameter int ADDR_W = 16,
  parameter int PERIOD_W = 16,
  localparam int IDX_W = $clog2(N)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [UTIL_W-1:0]   thresh,
  input  logic [PERIOD_W-1:0] decayPeriod,
  input  logic                evValid,
  output logic                evReady,
  input  logic [ADDR_W-1:0]   evAddr,
  input  logic [IDX_W-1:0]    evSrc,
  input  logic                evDirty,
  input  logic [N-1:0]        cloneMask,
  output logic [ADDR_W-1:0]   lineAddr,
  output logic                mergeValid,
  output logic [N-1:0]        mergeMask,
  output logic                offerValid,
  output logic [IDX_W-1:0]    offerTarget,
  output logic                offerDirty,
  input  logic                offerAck,
  input  logic                offerAccept,
  output logic                memValid,
  input  logic                memReady,
  output logic                resValid,
  output logic [1:0]          resCode,
  output logic [IDX_W-1:0]    resRegion
);
  ctrl_strobe_t strobe;
  logic allFull, cloneHit, reqDirty;
  logic [IDX_W-1:0] reqSrc;

  assign offerDirty = reqDirty;

  castout_ctrl ctrlI (
    .clk(clk), .rstN(rstN), .evValid(evValid), .allFull(allFull),
    .cloneHit(cloneHit), .reqDirty(reqDirty), .offerAck(offerAck),
    .offerAccept(offerAccept), .memReady(memReady), .evReady(evReady),
    .offerValid(offerValid), .memValid(memValid), .mergeValid(mergeValid),
    .strobe(strobe)
  );

  castout_dp #(.N(N), .UTIL_W(UTIL_W), .ADDR_W(ADDR_W), .PERIOD_W(PERIOD_W)) dpI (
    .clk(clk), .rstN(rstN), .strobe(strobe), .thresh(thresh),
    .decayPeriod(decayPeriod), .evAddr(evAddr), .evSrc(evSrc), .evDirty(evDirty),
    .cloneMask(cloneMask), .lineAddr(lineAddr), .reqSrc(reqSrc),
    .reqDirty(reqDirty), .cloneHit(cloneHit), .mergeMask(mergeMask),
    .allFull(allFull), .offerTarget(offerTarget), .resValid(resValid),
    .resCode(resCode), .resRegion(resRegion)
  );
endmodule

// File: rtl/castout_router_chk.sv
module castout_router_chk #(
  parameter int N = 8,
  parameter int ADDR_W = 16,
  localparam int IDX_W = $clog2(N)
) (
  input logic              clk,
  input logic              rstN,
  input logic              evReady,
  input logic [ADDR_W-1:0] lineAddr,
  input logic              mergeValid,
  input logic [N-1:0]      mergeMask,
  input logic              offerValid,
  input logic [IDX_W-1:0]  offerTarget,
  input logic              offerAck,
  input logic              memValid,
  input logic              memReady,
  input logic              resValid,
  input logic [1:0]        resCode,
  input logic [IDX_W-1:0]  reqSrc
);
  // R1
  busy_no_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    (offerValid || memValid || mergeValid) |-> !evReady);
  // R1
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({offerValid, memValid, mergeValid}));
  // R3
  merge_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    mergeValid |-> (mergeMask != '0) && !mergeMask[reqSrc]);
  // R3
  merge_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    mergeValid |=> resValid && resCode == 2'd1);
  // R4
  offer_not_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    offerValid |-> offerTarget != reqSrc);
  // R6
  offer_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    offerValid && !offerAck |=> offerValid && $stable(offerTarget) && $stable(lineAddr));
  // R8
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memValid && !memReady |=> memValid && $stable(lineAddr));
  // R10
  res_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    resValid |=> !resValid);
endmodule

bind castout_router castout_router_chk #(.N(N), .ADDR_W(ADDR_W)) chkI (
  .clk(clk), .rstN(rstN), .evReady(evReady), .lineAddr(lineAddr),
  .mergeValid(mergeValid), .mergeMask(mergeMask), .offerValid(offerValid),
  .offerTarget(offerTarget), .offerAck(offerAck), .memValid(memValid),
  .memReady(memReady), .resValid(resValid), .resCode(resCode), .reqSrc(reqSrc)
);

// File: tb/castout_router_test.sv
module castout_router_test;
  localparam int N = 8;
  localparam int UTIL_W = 3;
  localparam int ADDR_W = 16;
  localparam int PERIOD_W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [UTIL_W-1:0] thresh = 3'd7;
  logic [PERIOD_W-1:0] decayPeriod = '0;
  logic evValid = 1'b0, evDirty = 1'b0, offerAck = 1'b0, offerAccept = 1'b0, memReady = 1'b0;
  logic [ADDR_W-1:0] evAddr = '0;
  logic [2:0] evSrc = '0;
  logic [N-1:0] cloneMask = '0;
  logic evReady, mergeValid, offerValid, offerDirty, memValid, resValid;
  logic [ADDR_W-1:0] lineAddr;
  logic [N-1:0] mergeMask;
  logic [2:0] offerTarget, resRegion;
  logic [1:0] resCode;

  int checks = 0, fails = 0;
  int mu[N];
  int mrr = 0;

  always #5 clk = ~clk;

  castout_router uut (
    .clk(clk), .rstN(rstN), .thresh(thresh), .decayPeriod(decayPeriod),
    .evValid(evValid), .evReady(evReady), .evAddr(evAddr), .evSrc(evSrc),
    .evDirty(evDirty), .cloneMask(cloneMask), .lineAddr(lineAddr),
    .mergeValid(mergeValid), .mergeMask(mergeMask), .offerValid(offerValid),
    .offerTarget(offerTarget), .offerDirty(offerDirty), .offerAck(offerAck),
    .offerAccept(offerAccept), .memValid(memValid), .memReady(memReady),
    .resValid(resValid), .resCode(resCode), .resRegion(resRegion)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int predict(int src);
    int best = 99, t = 0;
    for (int k = 0; k < N; k++) begin
      int r = (mrr + k) % N;
      if (r != src && mu[r] < best) begin best = mu[r]; t = r; end
    end
    return t;
  endfunction

  task automatic start_ev(int src, int addr, bit dirty, logic [N-1:0] clones);
    @(negedge clk);
    chk("R1 ready while idle", evReady, 1);
    evValid = 1; evSrc = 3'(src); evAddr = 16'(addr); evDirty = dirty; cloneMask = clones;
    @(posedge clk);
    @(negedge clk);
    evValid = 0;
    chk("R1 not ready while busy", evReady, 0);
  endtask

  task automatic do_offer(int src, int addr, bit dirty, bit accept, logic [N-1:0] clones);
    int exp = predict(src);
    start_ev(src, addr, dirty, clones);
    chk("R3 no merge without peer clone", mergeValid, 0);
    @(negedge clk);
    chk("R4 offer raised", offerValid, 1);
    chk("R4 R5 offer target", offerTarget, exp);
    chk("R6 offer address", lineAddr, addr);
    @(negedge clk);
    chk("R6 offer held", offerValid, 1);
    offerAck = 1; offerAccept = accept;
    @(negedge clk);
    offerAck = 0; offerAccept = 0;
    if (accept) begin
      chk("R6 placed result", resValid, 1);
      chk("R6 placed code", resCode, 2);
      chk("R6 placed region", resRegion, exp);
      if (mu[exp] < 7) mu[exp]++;
      mrr = (mrr + 1) % N;
    end else if (dirty) begin
      chk("R7 dirty reject writes", memValid, 1);
      @(negedge clk);
      chk("R8 write held", memValid, 1);
      chk("R8 no result yet", resValid, 0);
      memReady = 1;
      @(negedge clk);
      memReady = 0;
      chk("R7 reject code", resCode, 3);
      chk("R7 reject result", resValid, 1);
      chk("R7 reject region", resRegion, exp);
    end else begin
      chk("R7 clean reject no write", memValid, 0);
      @(negedge clk);
      chk("R7 clean reject result", resValid, 1);
      chk("R7 clean reject code", resCode, 3);
    end
    chk("R1 ready again", evReady, 1);
  endtask

  task automatic do_merge(int src, int addr, logic [N-1:0] clones);
    start_ev(src, addr, 1, clones);
    chk("R3 merge strobe", mergeValid, 1);
    chk("R3 merge mask", mergeMask, clones & ~(8'd1 << src));
    chk("R3 no offer", offerValid, 0);
    @(negedge clk);
    chk("R3 merge result", resValid, 1);
    chk("R3 merge code", resCode, 1);
    chk("R10 region zero", resRegion, 0);
    chk("R3 no offer after", offerValid, 0);
  endtask

  task automatic do_mem(int src, int addr, bit dirty, logic [N-1:0] clones);
    start_ev(src, addr, dirty, clones);
    chk("R2 no merge when all full", mergeValid, 0);
    @(negedge clk);
    chk("R2 memory write", memValid, dirty);
    chk("R2 no offer", offerValid, 0);
    if (dirty) memReady = 1;
    @(negedge clk);
    memReady = 0;
    chk("R2 memory result", resValid, 1);
    chk("R2 memory code", resCode, 0);
    @(negedge clk);
    chk("R10 single pulse", resValid, 0);
  endtask

  initial begin
    #1_000_000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) mu[i] = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R1 reset ready", evReady, 1);
    chk("R10 reset no result", resValid, 0);
    chk("R6 reset no offer", offerValid, 0);
    chk("R8 reset no write", memValid, 0);

    // R4 R5 R6 R7: placements, ties and rejects
    do_offer(0, 'h100, 0, 1, '0);
    do_offer(0, 'h104, 1, 1, '0);
    do_offer(3, 'h108, 1, 0, '0);
    do_offer(4, 'h10c, 0, 0, '0);

    // R3: merge, and clone held only by source
    do_merge(2, 'h200, 8'b0010_0100);
    do_offer(5, 'h204, 0, 1, 8'b0010_0000);

    // fill every peer of region 0
    for (int i = 0; i < 4; i++) do_offer(0, 'h300 + i, 0, 1, '0);

    // R2: all peers above threshold; R9 no decay when period is 0
    thresh = 3'd0;
    do_mem(0, 'h400, 1, 8'b0000_0110);
    do_mem(0, 'h404, 0, '0);
    do_offer(1, 'h408, 0, 0, '0);

    // R9: decay to zero and hold there
    decayPeriod = 16'd5;
    repeat (60) @(negedge clk);
    for (int i = 0; i < N; i++) mu[i] = 0;
    do_offer(0, 'h500, 0, 1, '0);
    repeat (60) @(negedge clk);
    for (int i = 0; i < N; i++) mu[i] = 0;
    do_offer(1, 'h504, 0, 0, '0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule